// File: doc/BRIEF.md
# Band-Pass Digital Sigma-Delta Modulator

This block is a fully digital, multi-bit sigma-delta noise shaper whose quantization-noise notch sits at one quarter of the sample rate. Each sample clock it may accept one wide signed sample from a tone generator. It returns a 5-bit code, from 0 to 31, that tells a downstream mismatch-shaping element selector how many unit elements to switch on. Code 16 means zero.

The loop starts from a third-order low-pass prototype built from delaying integrators. The integrators are cascaded, the feedback is distributed, and a resonator path runs from the third state back to the second. Every unit delay of that prototype becomes a negated two-sample delay. The loop therefore acts as a sixth-order band-pass loop centred on Fs/4, sized for an oversampling ratio of 16. All loop coefficients are powers of two, so shifts and adds replace multipliers. A 16-bit maximal-length shift register supplies a small, centred dither that is added just ahead of the quantizer. An input can switch the dither off. The state registers clamp rather than wrap, and any clamp raises a sticky flag. The loop advances only on samples flagged valid, and each valid sample yields one output code one clock later.

Top module: `bpsd_modulator`

## Requirements
- R1: A synchronous reset clears all loop state and reseeds the dither register. While reset is held and on the first cycle after it, out_code is 16, out_valid is 0 and ovf is 0. The first valid sample after reset with zero input yields code 16, with or without dither.
- R2: out_valid equals the in_valid of the previous clock. Each valid input produces exactly one code one clock later.
- R3: A loop state whose next value leaves the signed ST_W range is clamped to the nearest limit. The clamp sets ovf on the following clock. ovf then stays at 1 until reset.
- R4: Let s1, s2 and s3 be the three states and fb the feedback. Each valid sample computes w1 = floor((u - fb)/4), w2 = floor((s1 - fb)/2) - floor(s3/32) and w3 = s2 - fb. Each state is then updated as s_k[n+2] = -(s_k[n] + w_k[n]), which is the -z^-2 form of an integrator.
- R5: Let y be s3 plus the dither d. The code is clamp(16 + floor((y + 1024)/2048), 0, 31) for the default 16-bit input, where the step is 2^(IN_W-5). The feedback is (code - 16) * 2048, computed from the same sample's code.
- R6: The dither is (L mod 512) - 256. L is a 16-bit shift register seeded with 0xACE1. On each valid sample L shifts left, and bit 0 takes bits 15^13^12^10. L advances on every valid sample whatever dith_en is. When dith_en is 0 the dither is 0.
- R7: With zero input and the dither off, every code stays at 16 indefinitely.
- R8: A cycle with in_valid at 0 leaves the loop state, the dither register and out_code unchanged, whatever in_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_data carries a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| dith_en | input | 1 | 1 adds dither ahead of the quantizer |
| out_valid | output | 1 | out_code was produced from a valid sample |
| out_code | output | 5 | Element count 0..31, 16 = zero |
| ovf | output | 1 | Sticky: a loop state was clamped since reset |

## Verification
The bench runs a bit-exact arithmetic model of the loop over a zero input, a sweep of DC levels, Fs/4 tones, sample streams with gaps, and a full-scale Fs/4 square wave. It compares every code and the overflow flag against the design. The full-scale square wave is the worst case: it drives the states into the clamp. A design that wrapped would produce codes unrelated to the model, and a flag that was not sticky would drop back to 0 afterwards. Samples with gaps carry garbage in_data on the idle cycles. A design that advanced its state, its dither register or its output on those cycles would fall out of step with the model at once. Dither is turned on and off mid-stream. A register that stalled while dither was disabled, or an offset that was not centred, shows up as wrong codes near the half-step decision points. An idle run with zero input checks that the notch loop stays silent.

// File: rtl/bpsd_pkg.sv
package bpsd_pkg;
  localparam int CODE_W    = 5;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int MID       = NUM_CODES / 2;
  localparam int N_STAGE   = 3;
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef logic [CODE_W-1:0] code_t;

  // Fibonacci form, taps 16,14,13,11 (maximal length)
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/bpsd_dither.sv
module bpsd_dither
  import bpsd_pkg::*;
#(
  parameter int DITH_W = 9,
  parameter int EW     = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 en,
  output logic signed [EW-1:0] dith
);
  localparam logic signed [EW-1:0] HALF =
    {{(EW-DITH_W){1'b0}}, 1'b1, {(DITH_W-1){1'b0}}};

  logic [LFSR_W-1:0]    lfsr_q;
  logic signed [EW-1:0] raw;

  always_ff @(posedge clk) begin
    if (rst)      lfsr_q <= LFSR_SEED;
    else if (adv) lfsr_q <= lfsr_step(lfsr_q);
  end

  assign raw  = {{(EW-DITH_W){1'b0}}, lfsr_q[DITH_W-1:0]};
  assign dith = en ? (raw - HALF) : '0;
endmodule

// File: rtl/bpsd_stage.sv
module bpsd_stage #(
  parameter int ST_W = 20,
  parameter int EW   = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic signed [EW-1:0]   w,
  output logic signed [ST_W-1:0] s,
  output logic                   sat
);
  localparam logic signed [EW-1:0] ST_MAX = {{(EW-ST_W+1){1'b0}}, {(ST_W-1){1'b1}}};
  localparam logic signed [EW-1:0] ST_MIN = {{(EW-ST_W+1){1'b1}}, {(ST_W-1){1'b0}}};

  logic signed [ST_W-1:0] near_q, far_q;
  logic signed [EW-1:0]   sum;

  function automatic logic signed [ST_W-1:0] clip(input logic signed [EW-1:0] x);
    if (x > ST_MAX) return ST_MAX[ST_W-1:0];
    if (x < ST_MIN) return ST_MIN[ST_W-1:0];
    return x[ST_W-1:0];
  endfunction

  // -z^-2 integrator: state two samples on is the negated sum
  assign sum = -(EW'(far_q) + w);
  assign sat = (sum > ST_MAX) || (sum < ST_MIN);
  assign s   = far_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      near_q <= '0;
      far_q  <= '0;
    end else if (adv) begin
      near_q <= clip(sum);
      far_q  <= near_q;
    end
  end
endmodule

// File: rtl/bpsd_quant.sv
module bpsd_quant
  import bpsd_pkg::*;
#(
  parameter int EW      = 24,
  parameter int STEP_LG = 11
) (
  input  logic signed [EW-1:0] y,
  output code_t                code,
  output logic signed [EW-1:0] fb
);
  localparam logic signed [EW-1:0] RND = EW'(1) << (STEP_LG-1);
  localparam logic signed [EW-1:0] LO  = '0;
  localparam logic signed [EW-1:0] HI  = EW'(NUM_CODES-1);
  localparam logic signed [EW-1:0] MX  = EW'(MID);

  function automatic code_t q_code(input logic signed [EW-1:0] v);
    logic signed [EW-1:0] q;
    q = ((v + RND) >>> STEP_LG) + MX;
    if (q < LO) return '0;
    if (q > HI) return HI[CODE_W-1:0];
    return q[CODE_W-1:0];
  endfunction

  function automatic logic signed [EW-1:0] level(input code_t c);
    logic signed [EW-1:0] cx;
    cx = EW'({1'b0, c}) - MX;
    return cx <<< STEP_LG;
  endfunction

  assign code = q_code(y);
  assign fb   = level(code);
endmodule

// File: rtl/bpsd_modulator.sv
module bpsd_modulator
  import bpsd_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int ST_W   = 20,
  parameter int DITH_W = 9,
  parameter int A1_SH  = 2,
  parameter int A2_SH  = 1,
  parameter int G_SH   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  input  logic                   dith_en,
  output logic                   out_valid,
  output logic [CODE_W-1:0]      out_code,
  output logic                   ovf
);
  localparam int EW      = ST_W + 4;
  localparam int STEP_LG = IN_W - CODE_W;

  logic signed [ST_W-1:0] st    [N_STAGE];
  logic signed [EW-1:0]   sx    [N_STAGE];
  logic signed [EW-1:0]   w_vec [N_STAGE];
  logic [N_STAGE-1:0]     sat_vec;
  logic signed [EW-1:0]   u_ext, y, fb, dith_val;
  code_t                  q_code;
  logic                   sat_event;

  bpsd_dither #(.DITH_W(DITH_W), .EW(EW)) u_dith (
    .clk(clk), .rst(rst), .adv(in_valid), .en(dith_en), .dith(dith_val)
  );

  for (genvar k = 0; k < N_STAGE; k++) begin : g_stg
    bpsd_stage #(.ST_W(ST_W), .EW(EW)) u_stg (
      .clk(clk), .rst(rst), .adv(in_valid),
      .w(w_vec[k]), .s(st[k]), .sat(sat_vec[k])
    );
    assign sx[k] = EW'(st[k]);
  end

  assign u_ext = EW'(in_data);
  assign y     = sx[N_STAGE-1] + dith_val;

  bpsd_quant #(.EW(EW), .STEP_LG(STEP_LG)) u_quant (
    .y(y), .code(q_code), .fb(fb)
  );

  // prototype CRFB: integrator inputs with power-of-two coefficients
  always_comb begin
    w_vec[0] = (u_ext - fb) >>> A1_SH;
    w_vec[1] = ((sx[0] - fb) >>> A2_SH) - (sx[2] >>> G_SH);
    w_vec[2] = sx[1] - fb;
  end

  assign sat_event = in_valid & (|sat_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code  <= code_t'(MID);
      out_valid <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)  out_code <= q_code;
      if (sat_event) ovf      <= 1'b1;
    end
  end
endmodule

// File: rtl/bpsd_modulator_chk.sv
module bpsd_modulator_chk
  import bpsd_pkg::*;
#(
  parameter int EW     = 24,
  parameter int DITH_W = 9
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 dith_en,
  input logic                 out_valid,
  input logic [CODE_W-1:0]    out_code,
  input logic                 ovf,
  input logic                 sat_event,
  input logic signed [EW-1:0] dith
);
  localparam logic signed [EW-1:0] HALF =
    {{(EW-DITH_W){1'b0}}, 1'b1, {(DITH_W-1){1'b0}}};

  p_reset_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_code == CODE_W'(MID) && !out_valid && !ovf));
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    sat_event |=> ovf);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  p_dither_off_r6: assert property (@(posedge clk) disable iff (rst)
    !dith_en |-> (dith == '0));
  p_dither_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (dith >= -HALF) && (dith < HALF));
  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_code));
endmodule

bind bpsd_modulator bpsd_modulator_chk #(.EW(EW), .DITH_W(DITH_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dith_en(dith_en),
  .out_valid(out_valid), .out_code(out_code), .ovf(ovf),
  .sat_event(sat_event), .dith(dith_val)
);

// File: tb/bpsd_modulator_bench.sv
`timescale 1ns/1ps
module bpsd_modulator_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic              dith_en = 1'b0;
  logic              out_valid;
  logic [4:0]        out_code;
  logic              ovf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bpsd_modulator u_bpsd_modulator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .dith_en(dith_en), .out_valid(out_valid), .out_code(out_code), .ovf(ovf)
  );

  // ---- arithmetic model ----
  longint m_near [3];
  longint m_far  [3];
  int     m_lfsr;
  bit     m_ovf;
  int     exp_code;
  bit     exp_valid;

  function automatic longint fdiv(input longint a, input longint d);
    if (a >= 0) return a / d;
    return -(((-a) + d - 1) / d);
  endfunction

  function automatic void m_reset();
    for (int k = 0; k < 3; k++) begin m_near[k] = 0; m_far[k] = 0; end
    m_lfsr = 'hACE1; m_ovf = 0; exp_code = 16; exp_valid = 0;
  endfunction

  function automatic int m_step(input longint u, input bit den);
    longint s1, s2, s3, d, y, q, fb, lim_hi, lim_lo;
    longint w [3];
    longint t;
    int c, fbit;
    s1 = m_far[0]; s2 = m_far[1]; s3 = m_far[2];
    d  = den ? longint'(m_lfsr % 512) - 256 : 0;
    y  = s3 + d;
    q  = fdiv(y + 1024, 2048);
    c  = int'(q) + 16;
    if (c < 0) c = 0;
    if (c > 31) c = 31;
    fb = longint'(c - 16) * 2048;
    w[0] = fdiv(u - fb, 4);
    w[1] = fdiv(s1 - fb, 2) - fdiv(s3, 32);
    w[2] = s2 - fb;
    lim_hi = (longint'(1) << 19) - 1;
    lim_lo = -(longint'(1) << 19);
    for (int k = 0; k < 3; k++) begin
      t = -(m_far[k] + w[k]);
      if (t > lim_hi) begin t = lim_hi; m_ovf = 1; end
      if (t < lim_lo) begin t = lim_lo; m_ovf = 1; end
      m_far[k]  = m_near[k];
      m_near[k] = t;
    end
    fbit = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
    m_lfsr = ((m_lfsr << 1) & 'hFFFF) | fbit;
    return c;
  endfunction

  // ---- checking ----
  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // one sample slot; called at a negedge
  task automatic slot(input bit v, input int u, input string req);
    in_valid = v;
    in_data  = 16'(u);
    if (v) begin
      exp_code  = m_step(longint'(u), dith_en);
      exp_valid = 1;
    end else begin
      exp_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2", "out_valid", longint'(out_valid), longint'(exp_valid));
    chk(req,  "out_code",  longint'(out_code),  longint'(exp_code));
    chk("R3", "ovf",       longint'(ovf),       longint'(m_ovf));
  endtask

  task automatic do_reset();
    in_valid = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1", "code in reset", longint'(out_code), 16);
    rst = 0;
    m_reset();
    @(negedge clk);
    chk("R1", "code after reset", longint'(out_code), 16);
    chk("R1", "valid after reset", longint'(out_valid), 0);
    chk("R1", "ovf after reset", longint'(ovf), 0);
  endtask

  initial begin
    #(4ns * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a;
    m_reset();
    @(negedge clk);
    do_reset();

    // R7 idle: zero input, dither off, stays at mid-scale
    dith_en = 0;
    for (int i = 0; i < 64; i++) begin
      slot(1, 0, "R7");
      chk("R7", "idle code", longint'(out_code), 16);
    end

    // R1 first valid output after reset, dither on
    do_reset();
    dith_en = 1;
    slot(1, 0, "R1");
    chk("R1", "first code", longint'(out_code), 16);

    // R4 R5 R6: Fs/4 tone with dither
    a = 8000;
    for (int i = 0; i < 400; i++)
      slot(1, (i % 4 == 0) ? a : ((i % 4 == 2) ? -a : 0), "R4");

    // R5 DC sweep, dither off
    do_reset();
    dith_en = 0;
    for (int lvl = -30000; lvl <= 30000; lvl += 5000)
      for (int i = 0; i < 40; i++) slot(1, lvl, "R5");

    // R8 gaps with garbage data on idle cycles
    do_reset();
    dith_en = 1;
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 1) slot(0, 12345 - i * 97, "R8");
      else            slot(1, ((i / 2) % 2 == 0) ? 6000 : -6000, "R8");
    end

    // R6 dither toggled mid-stream; register keeps running
    for (int i = 0; i < 200; i++) begin
      dith_en = (i / 7) % 2;
      slot(1, (i % 4 == 1) ? 3000 : ((i % 4 == 3) ? -3000 : 0), "R6");
    end

    // R3 full-scale Fs/4 square drives states into the clamp
    do_reset();
    dith_en = 0;
    for (int i = 0; i < 600; i++)
      slot(1, ((i / 2) % 2 == 0) ? 32767 : -32767, "R3");
    chk("R3", "ovf raised", longint'(ovf), 1);
    for (int i = 0; i < 20; i++) slot(1, 0, "R3");
    chk("R3", "ovf sticky", longint'(ovf), 1);

    // R1 reset clears the sticky flag
    do_reset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule